// File: doc/BRIEF.md
# Hot-Swap Gate Enable Controller

This block decides, every clock cycle, whether the gate drive of a hot-swap pass switch should be on. Three hardware supervisory signals feed it: a supply-good flag from the undervoltage comparator, an overvoltage flag and a timeout from the current-limit timer. Software sends requests through a small, already-decoded register-write port. It can veto the gate, lift the lock that keeps that veto unusable after reset, mask alert sources, and order a timed power cycle. Software can only ever remove the gate. It can never force the gate on against the hardware inputs.

Every supervisory event sets a sticky fault flag. The flags appear in an 8-bit summary status byte and drive a level alert output through a per-fault enable mask. The write port is a valid/ready channel. `wr_ready` goes high once reset is released and then stays high, so the port never applies back-pressure. Each accepted write gets exactly one response beat on the next cycle, and that beat carries an accept or reject flag. No response is ever dropped or delayed.

Top module: `hsw_gate_ctrl`

## Requirements
- R1: `gate_en` is high only when all of these held during the previous cycle: `uv_good` high, `ov` low, `oc_timeout` low, no latched overcurrent flag, the software ON bit at 1, and no power cycle running. When all of them hold, `gate_en` is high one clock edge later.
- R2: While `uv_good` is low or `ov` is high, `gate_en` stays low. In that state a write of ON=1 is accepted but does not raise the gate.
- R3: An accepted write of ON=0 lowers `gate_en` even when every hardware input would allow it on.
- R4: After reset the ON bit is 1, the command lock is closed, all alert enables are 1 and no fault flag is set. With these values `uv_good` alone turns the gate on and off.
- R5: A write to the on/off address (0) is rejected (`rsp_ack`=0, ON bit unchanged) while the unlock bit is 0. The unlock bit is bit 0 at configuration address 1. Once that bit is set, writes to the on/off address are accepted.
- R6: Each fault sets its own sticky flag on the edge after it is seen. The faults are a current-limit timeout, overvoltage, and `uv_good` low. A latched overcurrent flag keeps the gate off until the flags are cleared.
- R7: `alert` is high whenever a latched flag has its enable bit set. The enable bits are written at address 3: bit 0 is overcurrent, bit 1 is overvoltage, bit 2 is undervoltage.
- R8: An accepted ON=1 write that follows ON=0 clears every latched flag on the edge that accepts it.
- R9: An accepted write of data 1 to address 2 holds the gate off for `PC_CYCLES` cycles and then lets it return.
- R10: A power-cycle write that arrives while a cycle is running is accepted but does not extend or restart that cycle.
- R11: `wr_ready` is high from the first edge after reset. Every accepted write produces a one-cycle `rsp_valid` on the next cycle. Writes to an unused address are rejected.
- R12: The status byte reports the following bits: 0 gate on, 1 overcurrent flag, 2 overvoltage flag, 3 undervoltage flag, 4 ON bit, 5 unlock bit, 6 power cycle running, 7 alert.
- R13: A write with any data bit set above its field is rejected and changes nothing. The field is bit 0, or bits 2:0 for the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_good | input | 1 | Supply above undervoltage threshold |
| ov | input | 1 | Overvoltage detected |
| oc_timeout | input | 1 | Current-limit timer expired |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Write channel ready (held high after reset) |
| wr_addr | input | ADDR_W | Decoded command address |
| wr_data | input | DATA_W | Command data byte |
| rsp_valid | output | 1 | Response beat for the previous accepted write |
| rsp_ack | output | 1 | 1 accept, 0 reject |
| gate_en | output | 1 | Gate drive request |
| status | output | 8 | Summary status byte |
| alert | output | 1 | Level alert |

## Verification
Each result is due at a fixed cycle after its stimulus. A hardware input change shows in `gate_en` and the fault flags one edge later. A write's response appears one edge after the handshake, but its effect on the gate appears two edges after, because the ON bit register sits in front of the gate register. Mask and clear effects show in `alert` and `status` one edge after the write. The bench drives stimulus on falling edges and samples on the falling edge after the edge where each result is due. For the power cycle it counts falling edges from the accepting write and checks the last low cycle and the first high cycle exactly.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int unsigned NFAULT   = 3;
  localparam int unsigned F_OC     = 0;
  localparam int unsigned F_OV     = 1;
  localparam int unsigned F_UV     = 2;
  localparam int unsigned A_ONOFF  = 0;
  localparam int unsigned A_CFG    = 1;
  localparam int unsigned A_PCYC   = 2;
  localparam int unsigned A_MASK   = 3;

  typedef struct packed {
    logic       alert;
    logic       busy;
    logic       unlock;
    logic       on;
    logic [2:0] flt;   // uv, ov, oc
    logic       gate;
  } status_t;
endpackage

// File: rtl/hsw_cmd_regs.sv
module hsw_cmd_regs
  import hsw_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic              on_q,
  output logic              unlock_q,
  output logic [NFAULT-1:0] mask_q,
  output logic              clr_pulse,
  output logic              pc_start
);
  localparam logic [ADDR_W-1:0] AD_ON = ADDR_W'(A_ONOFF);
  localparam logic [ADDR_W-1:0] AD_CF = ADDR_W'(A_CFG);
  localparam logic [ADDR_W-1:0] AD_PC = ADDR_W'(A_PCYC);
  localparam logic [ADDR_W-1:0] AD_MK = ADDR_W'(A_MASK);

  logic fire, hit_on, hit_cf, hit_pc, hit_mk, rsv1_ok, rsvm_ok, acc;

  always_comb begin
    fire    = wr_valid & wr_ready;
    hit_on  = (wr_addr == AD_ON);
    hit_cf  = (wr_addr == AD_CF);
    hit_pc  = (wr_addr == AD_PC);
    hit_mk  = (wr_addr == AD_MK);
    rsv1_ok = ((wr_data >> 1) == '0);
    rsvm_ok = ((wr_data >> NFAULT) == '0);
    acc     = (hit_on & unlock_q & rsv1_ok) | (hit_cf & rsv1_ok) |
              (hit_pc & rsv1_ok & wr_data[0]) | (hit_mk & rsvm_ok);
    clr_pulse = fire & acc & hit_on & wr_data[0] & ~on_q;
    pc_start  = fire & acc & hit_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ready  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      on_q      <= 1'b1;
      unlock_q  <= 1'b0;
      mask_q    <= '1;
    end else begin
      wr_ready  <= 1'b1;
      rsp_valid <= fire;
      rsp_ack   <= fire & acc;
      if (fire && acc) begin
        if (hit_on) on_q     <= wr_data[0];
        if (hit_cf) unlock_q <= wr_data[0];
        if (hit_mk) mask_q   <= wr_data[NFAULT-1:0];
      end
    end
  end

  // R5: locked on/off writes are refused and leave the ON bit alone
  a_r5_locked_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_on && !unlock_q) |=> (rsp_valid && !rsp_ack && on_q == $past(on_q)));
  // R11: every handshake yields exactly one response beat next cycle
  a_r11_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
  // R13: reserved bits set on the unlock register write leave it unchanged
  a_r13_rsv_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_cf && !rsv1_ok) |=> (unlock_q == $past(unlock_q) && !rsp_ack));
endmodule

// File: rtl/hsw_fault_latch.sv
module hsw_fault_latch
  import hsw_pkg::*;
#(
  parameter int unsigned NF = NFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_in,
  input  logic          clr,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] lat,
  output logic          alert
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lat[i] <= 1'b0;
      else if (fault_in[i]) lat[i] <= 1'b1;
      else if (clr)         lat[i] <= 1'b0;
    end
    // R6: a seen fault is latched on the next edge
    a_r6_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in[i] |=> lat[i]);
    // R8: without a clear the flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[i] && !clr) |=> lat[i]);
  end

  assign alert = |(lat & mask);
endmodule

// File: rtl/hsw_pcycle_timer.sv
module hsw_pcycle_timer #(
  parameter int unsigned PC_CYCLES = 2000000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(PC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PC_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= LAST;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R9: an idle timer starts at the full count
  a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt == LAST));
  // R10: a request during a running cycle does not reload the count
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hsw_gate_ctrl.sv
module hsw_gate_ctrl
  import hsw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PC_CYCLES = 2000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_good,
  input  logic              ov,
  input  logic              oc_timeout,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic              gate_en,
  output logic [7:0]        status,
  output logic              alert
);
  logic              on_q, unlock_q, clr_pulse, pc_start, pc_busy;
  logic [NFAULT-1:0] mask_q, flt_in, flt_lat;
  status_t           st;

  hsw_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .on_q(on_q), .unlock_q(unlock_q), .mask_q(mask_q),
    .clr_pulse(clr_pulse), .pc_start(pc_start));

  always_comb begin
    flt_in       = '0;
    flt_in[F_OC] = oc_timeout;
    flt_in[F_OV] = ov;
    flt_in[F_UV] = ~uv_good;
  end

  hsw_fault_latch #(.NF(NFAULT)) u_flt (
    .clk(clk), .rst_n(rst_n), .fault_in(flt_in), .clr(clr_pulse),
    .mask(mask_q), .lat(flt_lat), .alert(alert));

  hsw_pcycle_timer #(.PC_CYCLES(PC_CYCLES)) u_pc (
    .clk(clk), .rst_n(rst_n), .start(pc_start), .busy(pc_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_en <= 1'b0;
    else gate_en <= uv_good & ~ov & ~oc_timeout & ~flt_lat[F_OC] & on_q & ~pc_busy;
  end

  always_comb begin
    st.gate   = gate_en;
    st.flt    = flt_lat;
    st.on     = on_q;
    st.unlock = unlock_q;
    st.busy   = pc_busy;
    st.alert  = alert;
    status    = st;
  end

  // R2: hardware out of range forces the gate off on the next edge
  a_r2_hw_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_good || ov || oc_timeout) |=> !gate_en);
  // R3: a cleared ON bit keeps the gate off
  a_r3_veto: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> !gate_en);
  // R1: a latched overcurrent flag blocks the gate
  a_r1_oc_block: assert property (@(posedge clk) disable iff (!rst_n)
    flt_lat[F_OC] |=> !gate_en);
  // R9: a running power cycle blocks the gate
  a_r9_busy_off: assert property (@(posedge clk) disable iff (!rst_n)
    pc_busy |=> !gate_en);
endmodule

// File: tb/tb_hsw_gate_ctrl.sv
module tb_hsw_gate_ctrl;
  localparam int unsigned PCN = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic uv_good = 1'b1, ov = 1'b0, oc_timeout = 1'b0;
  logic wr_valid = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, rsp_valid, rsp_ack, gate_en, alert;
  logic [7:0] status;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  hsw_gate_ctrl #(.ADDR_W(4), .DATA_W(8), .PC_CYCLES(PCN)) dut (
    .clk(clk), .rst_n(rst_n), .uv_good(uv_good), .ov(ov), .oc_timeout(oc_timeout),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .gate_en(gate_en),
    .status(status), .alert(alert));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one write at a falling edge, return at the falling edge after it is taken
  task automatic wr(string req, logic [3:0] a, logic [7:0] d, logic exp_ack);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " rsp_ack"}, 32'(rsp_ack), 32'(exp_ack));
  endtask

  task automatic clear_faults();
    wr("R8 clr off", 4'd0, 8'h00, 1'b1);
    wr("R8 clr on", 4'd0, 8'h01, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready", 32'(wr_ready), 32'd1);
    check("R4 gate after reset", 32'(gate_en), 32'd1);
    check("R12 R4 status after reset", 32'(status), 32'h11);
    check("R4 alert after reset", 32'(alert), 32'd0);
  endtask

  task automatic t_uv_master();
    uv_good = 1'b0; @(negedge clk);
    check("R4 uv off", 32'(gate_en), 32'd0);
    check("R6 uv flag", 32'(status[3]), 32'd1);
    check("R7 alert on uv", 32'(alert), 32'd1);
    uv_good = 1'b1; @(negedge clk);
    check("R4 uv back on", 32'(gate_en), 32'd1);
    check("R12 status uv latched", 32'(status), 32'h99);
  endtask

  task automatic t_lock();
    wr("R5 locked off", 4'd0, 8'h00, 1'b0);
    @(negedge clk);
    check("R5 gate unchanged", 32'(gate_en), 32'd1);
    check("R5 on bit kept", 32'(status[4]), 32'd1);
    wr("R5 unlock", 4'd1, 8'h01, 1'b1);
    check("R5 unlock bit", 32'(status[5]), 32'd1);
    clear_faults();
    check("R8 cleared status", 32'(status), 32'h31);
    check("R8 alert cleared", 32'(alert), 32'd0);
  endtask

  task automatic t_veto();
    wr("R3 off", 4'd0, 8'h00, 1'b1);
    @(negedge clk);
    check("R3 gate vetoed", 32'(gate_en), 32'd0);
    check("R3 on bit", 32'(status[4]), 32'd0);
  endtask

  task automatic t_hw_wins();
    uv_good = 1'b0; @(negedge clk);
    wr("R2 on under uv", 4'd0, 8'h01, 1'b1);
    repeat (3) @(negedge clk);
    check("R2 gate stays off uv", 32'(gate_en), 32'd0);
    uv_good = 1'b1; @(negedge clk);
    check("R2 gate back", 32'(gate_en), 32'd1);
    ov = 1'b1; @(negedge clk);
    check("R2 ov off", 32'(gate_en), 32'd0);
    check("R6 ov flag", 32'(status[2]), 32'd1);
    wr("R2 on under ov", 4'd0, 8'h01, 1'b1);
    @(negedge clk);
    check("R2 gate stays off ov", 32'(gate_en), 32'd0);
    ov = 1'b0; @(negedge clk);
    check("R2 gate after ov", 32'(gate_en), 32'd1);
    check("R7 alert ov", 32'(alert), 32'd1);
    clear_faults();
  endtask

  task automatic t_oc();
    oc_timeout = 1'b1; @(negedge clk);
    oc_timeout = 1'b0;
    check("R6 oc off", 32'(gate_en), 32'd0);
    repeat (4) @(negedge clk);
    check("R6 oc latched blocks", 32'(gate_en), 32'd0);
    check("R12 oc status", 32'(status), 32'hB2);
    wr("R8 off", 4'd0, 8'h00, 1'b1);
    wr("R8 on", 4'd0, 8'h01, 1'b1);
    check("R8 flags cleared", 32'(status[3:1]), 32'd0);
    @(negedge clk);
    check("R8 gate restored", 32'(gate_en), 32'd1);
  endtask

  task automatic t_mask();
    ov = 1'b1; @(negedge clk); ov = 1'b0; @(negedge clk);
    check("R7 alert from ov", 32'(alert), 32'd1);
    wr("R7 mask ov", 4'd3, 8'h05, 1'b1);
    check("R7 alert masked", 32'(alert), 32'd0);
    check("R7 flag still set", 32'(status[2]), 32'd1);
    wr("R13 mask rsv", 4'd3, 8'h0F, 1'b0);
    check("R13 mask kept", 32'(alert), 32'd0);
    wr("R7 unmask", 4'd3, 8'h07, 1'b1);
    check("R7 alert unmasked", 32'(alert), 32'd1);
    clear_faults();
  endtask

  task automatic t_rsv_addr();
    wr("R13 on rsv", 4'd0, 8'h02, 1'b0);
    @(negedge clk);
    check("R13 on unchanged", 32'(status[4]), 32'd1);
    check("R13 gate unchanged", 32'(gate_en), 32'd1);
    wr("R11 bad addr", 4'hA, 8'h01, 1'b0);
    @(negedge clk);
    check("R11 no response idle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_pcycle();
    wr("R9 start", 4'd2, 8'h01, 1'b1);          // now after edge k
    @(negedge clk);                            // after k+1
    check("R9 gate off", 32'(gate_en), 32'd0);
    repeat (3) @(negedge clk);                 // after k+4
    wr("R10 second", 4'd2, 8'h01, 1'b1);        // after k+5
    check("R12 busy bit", 32'(status[6]), 32'd1);
    repeat (15) @(negedge clk);                // after k+20
    check("R10 last low cycle", 32'(gate_en), 32'd0);
    @(negedge clk);                            // after k+21
    check("R9 R10 gate returns", 32'(gate_en), 32'd1);
    check("R9 busy clear", 32'(status[6]), 32'd0);
  endtask

  initial begin
    fork
      begin : wd
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
      begin
        t_reset();
        t_uv_master();
        t_lock();
        t_veto();
        t_hw_wins();
        t_oc();
        t_mask();
        t_rsv_addr();
        t_pcycle();
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule